// File: doc/BRIEF.md
# Drift-Corrected Nanosecond Time Counter

This block keeps a 64-bit count of nanoseconds. On every clock it adds the clock period, which is set by a parameter. At a programmed interval it also applies a small signed correction so that the count tracks a reference rate. Software works out the correction from a frequency error. It then programs the block through a simple register port as a packed word that holds three things: a period in 16 ns units, a step of 0 to 7 ns, and a direction.

The same port lets software stop and restart the count and load a new 64-bit value while it is stopped. It also controls a drift-reset bit that must be high for a new correction word to be accepted. The time can be read as two 32-bit halves: low first, then high. The full value is also driven on a wide output for timestamping logic beside the block.

Top module: `ns_time_counter`

## Requirements
- R1: After reset the time is 0 and the counter is running. The correction word reads 0, the drift-reset bit reads 0 and rd_data is 0.
- R2: While running, on a cycle with no correction, the time grows by CLK_NS (default 4) on each clock, modulo 2^64.
- R3: The correction word (address 3) is decoded as follows. Bits 27:0 are the period in 16 ns units. Bits 30:28 are the step. Bit 31 set means add and clear means subtract. On a correction cycle the increment is CLK_NS+step or CLK_NS-step, modulo 2^64. No other cycle's increment changes.
- R4: The correction interval is period*16+8 ns. Each running cycle adds CLK_NS to an elapsed-ns accumulator. A correction falls on the cycle where the accumulator plus CLK_NS reaches the interval, and only the excess over the interval is kept.
- R5: A write to address 3 changes the correction word only while the drift-reset bit is 1. Otherwise the write is ignored.
- R6: The drift-reset bit is bit 0 of address 4, and a read returns it in bit 0. While it is 1, no correction occurs and the accumulator is held at 0. The first correction after the bit is cleared therefore falls one full interval later.
- R7: A correction word of 0 disables correction, and the accumulator is held at 0.
- R8: Address 2 is the run control. Writing 2 stops the count and writing 4 restarts it; any other value is ignored. A read returns 1 in bit 0 while stopped. While stopped, the time and the accumulator hold.
- R9: While stopped, a write to address 0 loads time bits 31:0 and a write to address 1 loads bits 63:32. The same writes are ignored while running.
- R10: Reads have one cycle of latency. Address 0 returns time bits 31:0 and captures bits 63:32. Address 1 returns the captured half, so a low-then-high pair is coherent across a carry. Addresses 2, 3 and 4 read back their registers. Other addresses return 0, and rd_data holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| time_o | output | 64 | Current time in nanoseconds |

## Verification
A wrong accumulator or a wrongly decoded correction word shows up on time_o on the very next clock. It appears as one increment differing from CLK_NS, or as a correction one cycle early or late, so the bench compares time_o against its model on every clock. A wrong run, drift-reset or correction register shows up as a wrong read-back one cycle after the read. If the captured high half is wrong, the second read of a pair disagrees with the time at which the low half was read.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int TIME_W = 2 * DATA_W;
    localparam int PER_W  = 28;
    localparam int STEP_W = 3;
    localparam int INTV_W = PER_W + 4;

    localparam logic [ADDR_W-1:0] A_TLO  = 3'd0;
    localparam logic [ADDR_W-1:0] A_THI  = 3'd1;
    localparam logic [ADDR_W-1:0] A_RUN  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CFG  = 3'd3;
    localparam logic [ADDR_W-1:0] A_DRST = 3'd4;

    localparam logic [DATA_W-1:0] CMD_STOP  = 32'd2;
    localparam logic [DATA_W-1:0] CMD_START = 32'd4;

    typedef struct packed {
        logic              add;
        logic [STEP_W-1:0] step;
        logic [PER_W-1:0]  period;
    } drift_cfg_t;
endpackage

// File: rtl/ntc_regs.sv
module ntc_regs
    import ntc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [TIME_W-1:0] time_i,
    output logic              stopped_o,
    output drift_cfg_t        cfg_o,
    output logic              drst_o,
    output logic              load_lo_o,
    output logic              load_hi_o,
    output logic [DATA_W-1:0] rd_data_o
);
    typedef struct packed {
        logic              stopped;
        drift_cfg_t        cfg;
        logic              drst;
        logic [DATA_W-1:0] snap;
        logic [DATA_W-1:0] rd;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                A_RUN: begin
                    if (wr_data == CMD_STOP)       st_d.stopped = 1'b1;
                    else if (wr_data == CMD_START) st_d.stopped = 1'b0;
                end
                A_CFG:   if (st_q.drst) st_d.cfg = drift_cfg_t'(wr_data);
                A_DRST:  st_d.drst = wr_data[0];
                default: ;
            endcase
        end
        if (rd_en) begin
            case (rd_addr)
                A_TLO: begin
                    st_d.rd   = time_i[DATA_W-1:0];
                    st_d.snap = time_i[TIME_W-1:DATA_W];
                end
                A_THI:   st_d.rd = st_q.snap;
                A_RUN:   st_d.rd = {{(DATA_W-1){1'b0}}, st_q.stopped};
                A_CFG:   st_d.rd = DATA_W'(st_q.cfg);
                A_DRST:  st_d.rd = {{(DATA_W-1){1'b0}}, st_q.drst};
                default: st_d.rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stopped_o = st_q.stopped;
    assign cfg_o     = st_q.cfg;
    assign drst_o    = st_q.drst;
    assign rd_data_o = st_q.rd;
    assign load_lo_o = wr_en && (wr_addr == A_TLO) && st_q.stopped;
    assign load_hi_o = wr_en && (wr_addr == A_THI) && st_q.stopped;
endmodule

// File: rtl/ntc_drift.sv
module ntc_drift #(
    parameter int CLK_NS = 4,
    parameter int INTV_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              enable,
    input  logic [INTV_W-1:0] interval,
    output logic              fire
);
    localparam int ACC_W = INTV_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } drift_t;

    drift_t st_d, st_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        sum  = st_q.acc + ACC_W'(CLK_NS);
        if (!enable) begin
            st_d.acc = '0;
        end else if (run) begin
            if (sum >= {1'b0, interval}) begin
                fire     = 1'b1;
                st_d.acc = sum - {1'b0, interval};
            end else begin
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ntc_time.sv
module ntc_time #(
    parameter int CLK_NS = 4,
    parameter int TIME_W = 64,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              fire,
    input  logic              add,
    input  logic [STEP_W-1:0] step,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic [TIME_W/2-1:0] load_data,
    output logic [TIME_W-1:0] time_o
);
    localparam int HALF = TIME_W / 2;

    typedef struct packed {
        logic [TIME_W-1:0] t;
    } time_t;

    time_t st_d, st_q;
    logic [TIME_W-1:0] delta;

    always_comb begin
        st_d  = st_q;
        delta = TIME_W'(CLK_NS);
        if (fire) begin
            if (add) delta = delta + TIME_W'(step);
            else     delta = delta - TIME_W'(step);
        end
        if (run)     st_d.t = st_q.t + delta;
        if (load_lo) st_d.t[HALF-1:0] = load_data;
        if (load_hi) st_d.t[TIME_W-1:HALF] = load_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign time_o = st_q.t;
endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter
    import ntc_pkg::*;
#(
    parameter int CLK_NS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [TIME_W-1:0] time_o
);
    logic              stopped_w;
    drift_cfg_t        cfg_w;
    logic              drst_w;
    logic              load_lo_w;
    logic              load_hi_w;
    logic              fire_w;
    logic              drift_en_w;
    logic [INTV_W-1:0] interval_w;

    assign interval_w = {cfg_w.period, 4'b0000} + INTV_W'(8);
    assign drift_en_w = (cfg_w != '0) && !drst_w;

    ntc_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .time_i(time_o),
        .stopped_o(stopped_w), .cfg_o(cfg_w), .drst_o(drst_w),
        .load_lo_o(load_lo_w), .load_hi_o(load_hi_w), .rd_data_o(rd_data)
    );

    ntc_drift #(.CLK_NS(CLK_NS), .INTV_W(INTV_W)) u_drift (
        .clk(clk), .rst_n(rst_n), .run(!stopped_w), .enable(drift_en_w),
        .interval(interval_w), .fire(fire_w)
    );

    ntc_time #(.CLK_NS(CLK_NS), .TIME_W(TIME_W), .STEP_W(STEP_W)) u_time (
        .clk(clk), .rst_n(rst_n), .run(!stopped_w), .fire(fire_w),
        .add(cfg_w.add), .step(cfg_w.step),
        .load_lo(load_lo_w), .load_hi(load_hi_w), .load_data(wr_data),
        .time_o(time_o)
    );
endmodule

// File: rtl/ntc_checks.sv
module ntc_checks
    import ntc_pkg::*;
#(
    parameter int CLK_NS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stopped,
    input logic              fire,
    input logic              drst,
    input logic [DATA_W-1:0] cfg,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [TIME_W-1:0] time_v
);
    // R2: plain increment on uncorrected running cycles
    assert_plain_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !stopped && !fire |=> time_v == $past(time_v) + TIME_W'(CLK_NS));

    // R3: additive correction
    assert_corr_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !stopped && fire && cfg[31] |=>
        time_v == $past(time_v) + TIME_W'(CLK_NS) + TIME_W'($past(cfg[30:28])));

    // R3: subtractive correction
    assert_corr_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !stopped && fire && !cfg[31] |=>
        time_v == $past(time_v) + TIME_W'(CLK_NS) - TIME_W'($past(cfg[30:28])));

    // R5: correction word gated by drift-reset
    assert_cfg_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == A_CFG && !drst |=> $stable(cfg));

    // R6: no correction while drift-reset is high
    assert_drst_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drst |-> !fire);

    // R7: zero word disables correction
    assert_zero_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg == '0 |-> !fire);

    // R8: stopped time holds unless loaded
    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stopped && !(wr_en && (wr_addr == A_TLO || wr_addr == A_THI)) |=> $stable(time_v));
endmodule

bind ns_time_counter ntc_checks #(.CLK_NS(CLK_NS)) u_chk (
    .clk(clk), .rst_n(rst_n), .stopped(stopped_w), .fire(fire_w),
    .drst(drst_w), .cfg(cfg_w), .wr_en(wr_en), .wr_addr(wr_addr),
    .time_v(time_o)
);

// File: tb/sim_ns_time_counter.sv
`timescale 1ns/1ps
module sim_ns_time_counter;
    localparam int CLK_NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] time_o;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    string tag = "R1";

    always #2 clk = ~clk;

    ns_time_counter #(.CLK_NS(CLK_NS)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .time_o(time_o)
    );

    // behavioural reference
    logic [63:0] m_time;
    bit          m_stop;
    logic [31:0] m_cfg;
    bit          m_drst;
    longint      m_acc;
    logic [31:0] m_snap;
    logic [31:0] m_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_time = 0; m_stop = 0; m_cfg = 0; m_drst = 0;
            m_acc = 0; m_snap = 0; m_rd = 0;
        end else begin
            longint      intv, nacc;
            bit          corr;
            logic [63:0] nt;
            bit          nstop, ndrst;
            logic [31:0] ncfg, nsnap, nrd;
            intv = longint'(m_cfg[27:0]) * 16 + 8;
            corr = 0;
            nacc = m_acc;
            if (m_cfg == 0 || m_drst) nacc = 0;
            else if (!m_stop) begin
                nacc = m_acc + CLK_NS;
                if (nacc >= intv) begin corr = 1; nacc = nacc - intv; end
            end
            nt = m_time;
            if (!m_stop) begin
                nt = nt + CLK_NS;
                if (corr) nt = m_cfg[31] ? nt + m_cfg[30:28] : nt - m_cfg[30:28];
            end
            if (wr_en && m_stop && wr_addr == 0) nt[31:0] = wr_data;
            if (wr_en && m_stop && wr_addr == 1) nt[63:32] = wr_data;
            nstop = m_stop; ncfg = m_cfg; ndrst = m_drst;
            if (wr_en && wr_addr == 2 && wr_data == 2) nstop = 1;
            if (wr_en && wr_addr == 2 && wr_data == 4) nstop = 0;
            if (wr_en && wr_addr == 3 && m_drst) ncfg = wr_data;
            if (wr_en && wr_addr == 4) ndrst = wr_data[0];
            nsnap = m_snap; nrd = m_rd;
            if (rd_en) begin
                case (rd_addr)
                    3'd0: begin nrd = m_time[31:0]; nsnap = m_time[63:32]; end
                    3'd1: nrd = m_snap;
                    3'd2: nrd = {31'b0, m_stop};
                    3'd3: nrd = m_cfg;
                    3'd4: nrd = {31'b0, m_drst};
                    default: nrd = 0;
                endcase
            end
            m_time = nt; m_stop = nstop; m_cfg = ncfg; m_drst = ndrst;
            m_acc = nacc; m_snap = nsnap; m_rd = nrd;
        end
    end

    task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", t, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({tag, " time_o"}, time_o, m_time);
            chk({tag, " rd_data"}, {32'b0, rd_data}, {32'b0, m_rd});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1; rd_addr = a;
        @(negedge clk); rd_en = 0; d = rd_data;
    endtask

    task automatic count_deltas(input int n, input logic [63:0] val, output int hits);
        logic [63:0] prev;
        hits = 0;
        prev = time_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (time_o - prev == val) hits++;
            prev = time_o;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, lo, hi;
        logic [63:0] t0;
        int hits;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 time in reset", time_o, 64'd0);
        chk("R1 rd_data in reset", {32'b0, rd_data}, 64'd0);
        rst_n = 1;
        rd(3'd2, v); chk("R1 run reg", {32'b0, v}, 64'd0);
        rd(3'd3, v); chk("R1 cfg reg", {32'b0, v}, 64'd0);
        rd(3'd4, v); chk("R1 drst reg", {32'b0, v}, 64'd0);

        // R2 plain increments
        tag = "R2";
        t0 = time_o;
        repeat (5) @(negedge clk);
        chk("R2 five cycles", time_o, t0 + 64'd20);

        // R5 cfg write ignored while drift-reset low
        tag = "R5";
        wr(3'd3, 32'hB000_0002);
        rd(3'd3, v); chk("R5 cfg ignored", {32'b0, v}, 64'd0);

        // R6 drift-reset, R3/R4 additive correction every 40 ns
        tag = "R6";
        wr(3'd4, 32'd1);
        rd(3'd4, v); chk("R6 drst readback", {32'b0, v}, 64'd1);
        wr(3'd3, 32'hB000_0002);
        rd(3'd3, v); chk("R5 cfg accepted", {32'b0, v}, 64'hB000_0002);
        count_deltas(15, 64'd4, hits);
        chk("R6 no correction while drst", hits, 15);
        wr(3'd4, 32'd0);
        tag = "R4";
        count_deltas(40, 64'd7, hits);
        chk("R4 four corrections in 40 cycles", hits, 4);

        // R3 subtractive correction every 8 ns
        tag = "R3";
        wr(3'd4, 32'd1);
        wr(3'd3, 32'h7000_0000);
        wr(3'd4, 32'd0);
        repeat (2) @(negedge clk);
        count_deltas(20, 64'hFFFF_FFFF_FFFF_FFFD, hits);
        chk("R3 subtract step 7", hits, 10);

        // R7 zero word disables
        tag = "R7";
        wr(3'd4, 32'd1);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd0);
        count_deltas(20, 64'd4, hits);
        chk("R7 no corrections", hits, 20);

        // R9 load ignored while running
        tag = "R9";
        t0 = time_o;
        wr(3'd0, 32'h1234_5678);
        chk("R9 load ignored running", time_o, t0 + 64'd8);

        // R8 run control
        tag = "R8";
        wr(3'd2, 32'd1);
        rd(3'd2, v); chk("R8 other value ignored", {32'b0, v}, 64'd0);
        wr(3'd2, 32'd2);
        rd(3'd2, v); chk("R8 stopped flag", {32'b0, v}, 64'd1);
        t0 = time_o;
        repeat (5) @(negedge clk);
        chk("R8 time holds", time_o, t0);

        // R9 load while stopped
        tag = "R9";
        wr(3'd0, 32'hFFFF_FFF0);
        wr(3'd1, 32'd1);
        chk("R9 loaded value", time_o, 64'h1_FFFF_FFF0);
        wr(3'd2, 32'd4);
        rd(3'd2, v); chk("R8 restarted", {32'b0, v}, 64'd0);

        // R10 coherent read across carry
        tag = "R10";
        while (time_o[31:0] != 32'hFFFF_FFFC && time_o[63:32] == 32'd1) @(negedge clk);
        rd_en = 1; rd_addr = 3'd0;
        @(negedge clk); lo = rd_data; rd_addr = 3'd1;
        @(negedge clk); hi = rd_data; rd_en = 0;
        chk("R10 low half", {32'b0, lo}, 64'hFFFF_FFFC);
        chk("R10 captured high half", {32'b0, hi}, 64'd1);
        chk("R10 carry happened", {32'b0, time_o[63:32]}, 64'd2);
        rd(3'd5, v); chk("R10 unmapped reads 0", {32'b0, v}, 64'd0);
        repeat (4) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule